// File: doc/BRIEF.md
# Serial Digit-Write Controller

This block takes display digits one at a time from a three-wire serial link and keeps them in a small register file. Each frame carries two annunciator flags, a 4-bit character code and a 4-bit digit address. The sender shifts the bits in on rising edges of a data clock. After at least eight bits, the block pulls its active-low ready handshake low. The sender then pulses the active-low write strobe, and the rising edge of that strobe stores the frame into the addressed digit.

All three link inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block detects rising edges on the synchronized copies. The sender may shorten a frame to nine or eight bits by dropping leading annunciator flags, and the dropped flags read as off. The block exposes every stored digit at once on a flat bus for a display scanner.

Top module: `serdig_if`

## Requirements
- R1: Frame bits arrive in this order: annunciator 1, annunciator 2, code bits 0 to 3, address bits 0 to 3. Code bit 0 is the least significant code bit and address bit 0 the least significant address bit. A committed digit entry holds {ann1, ann2, code[3:0]}, with ann1 in bit 5. Digit d occupies bits d*6+5 down to d*6 of `digits_flat`.
- R2: `accepted_n` stays high while fewer than eight bits of the current frame have arrived. It is low after the eighth, ninth and tenth bits.
- R3: An eight-bit frame stores the code with both annunciators 0. A nine-bit frame stores ann2 from its first bit with ann1 at 0. A ten-bit frame stores both flags.
- R4: The eleventh data-clock edge of a frame discards the frame and returns `accepted_n` high. A write strobe that follows it changes no digit.
- R5: A write-strobe rising edge while `accepted_n` is low stores the entry into the addressed digit. It then clears the frame, so `accepted_n` returns high.
- R6: A write-strobe rising edge while `accepted_n` is high changes no digit. It clears any partial frame, so the next frame lands correctly.
- R7: A committed frame whose address is 10 to 15 changes no digit and still clears the frame.
- R8: Synchronous reset clears every digit to 0 and leaves `accepted_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data bit (asynchronous) |
| ser_clk | input | 1 | Serial data clock; rising edge shifts (asynchronous) |
| ser_wr_n | input | 1 | Active-low write strobe; rising edge acts (asynchronous) |
| accepted_n | output | 1 | Low once a frame of at least eight bits is held |
| digits_flat | output | 60 | All ten 6-bit digit entries, digit 0 in the low bits |

## Verification
A pin edge takes three system clocks to reach a result: two synchronizer flops, then the edge-detect register that feeds the frame logic. The edge therefore reaches `accepted_n` and `digits_flat` at the third rising clock after the pin changes. The bench holds each serial pin level for at least three system clocks. It samples the outputs on a falling clock edge no earlier than three clocks after the last pin edge, so every result has settled before it is read.

// File: rtl/serdig_pkg.sv
package serdig_pkg;
  localparam int DEF_DIGITS = 10;
  localparam int DEF_ANN_W  = 2;
  localparam int DEF_CODE_W = 4;
  localparam int DEF_ADDR_W = 4;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/serdig_sync.sv
module serdig_sync #(
  parameter int STAGES = serdig_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/serdig_frame_rx.sv
module serdig_frame_rx #(
  parameter int ANN_W  = serdig_pkg::DEF_ANN_W,
  parameter int CODE_W = serdig_pkg::DEF_CODE_W,
  parameter int ADDR_W = serdig_pkg::DEF_ADDR_W,
  localparam int FRAME_MAX = ANN_W + CODE_W + ADDR_W,
  localparam int FRAME_MIN = CODE_W + ADDR_W,
  localparam int CNT_W     = $clog2(FRAME_MAX + 1),
  localparam int ENTRY_W   = ANN_W + CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_in,
  input  logic               clk_rise,
  input  logic               wr_rise,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               accepted_n,
  output logic               commit,
  output logic [ADDR_W-1:0]  frame_addr,
  output logic [ENTRY_W-1:0] frame_entry
);
  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     cnt_nxt;
  logic [FRAME_MAX-1:0] sh_nxt;

  always_comb begin
    cnt_nxt = bit_cnt;
    sh_nxt  = shreg;
    if (wr_rise) begin
      cnt_nxt = '0;
      sh_nxt  = '0;
    end else if (clk_rise) begin
      if (bit_cnt == CNT_W'(FRAME_MAX)) begin
        cnt_nxt = '0;
        sh_nxt  = '0;
      end else begin
        cnt_nxt = bit_cnt + 1'b1;
        sh_nxt  = {shreg[FRAME_MAX-2:0], bit_in};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      accepted_n <= 1'b1;
    end else begin
      bit_cnt    <= cnt_nxt;
      shreg      <= sh_nxt;
      accepted_n <= (cnt_nxt < CNT_W'(FRAME_MIN));
    end
  end

  // Newest bit sits at index 0, so field bit order is reversed.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    assign frame_addr[i] = shreg[ADDR_W-1-i];
  end
  for (genvar i = 0; i < CODE_W; i++) begin : g_code
    assign frame_entry[i] = shreg[FRAME_MIN-1-i];
  end
  assign frame_entry[ENTRY_W-1:CODE_W] = shreg[FRAME_MAX-1:FRAME_MIN];

  assign commit = wr_rise & ~accepted_n;
endmodule

// File: rtl/serdig_regfile.sv
module serdig_regfile #(
  parameter int DIGITS  = serdig_pkg::DEF_DIGITS,
  parameter int ADDR_W  = serdig_pkg::DEF_ADDR_W,
  parameter int ENTRY_W = serdig_pkg::DEF_ANN_W + serdig_pkg::DEF_CODE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [ENTRY_W-1:0]        wr_data,
  output logic [DIGITS*ENTRY_W-1:0] flat
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [ENTRY_W-1:0] entry;
    always_ff @(posedge clk) begin
      if (rst)
        entry <= '0;
      else if (wr_en && (int'(wr_addr) == d))
        entry <= wr_data;
    end
    assign flat[d*ENTRY_W +: ENTRY_W] = entry;
  end
endmodule

// File: rtl/serdig_if.sv
module serdig_if #(
  parameter int DIGITS = serdig_pkg::DEF_DIGITS,
  parameter int ANN_W  = serdig_pkg::DEF_ANN_W,
  parameter int CODE_W = serdig_pkg::DEF_CODE_W,
  parameter int ADDR_W = serdig_pkg::DEF_ADDR_W,
  localparam int ENTRY_W   = ANN_W + CODE_W,
  localparam int FRAME_MAX = ANN_W + CODE_W + ADDR_W,
  localparam int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_data,
  input  logic                      ser_clk,
  input  logic                      ser_wr_n,
  output logic                      accepted_n,
  output logic [DIGITS*ENTRY_W-1:0] digits_flat
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins, lvl, rises;
  logic             clk_rise, wr_rise, data_s, commit;
  logic [CNT_W-1:0]   bit_cnt;
  logic [ADDR_W-1:0]  frame_addr;
  logic [ENTRY_W-1:0] frame_entry;

  assign pins = {ser_wr_n, ser_clk, ser_data};

  for (genvar p = 0; p < NPINS; p++) begin : g_sync
    serdig_sync u_sync (
      .clk(clk), .rst(rst), .pin(pins[p]), .level(lvl[p]), .rise(rises[p])
    );
  end

  assign data_s   = lvl[0];
  assign clk_rise = rises[1];
  assign wr_rise  = rises[2];

  serdig_frame_rx #(.ANN_W(ANN_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst(rst), .bit_in(data_s), .clk_rise(clk_rise),
    .wr_rise(wr_rise), .bit_cnt(bit_cnt), .accepted_n(accepted_n),
    .commit(commit), .frame_addr(frame_addr), .frame_entry(frame_entry)
  );

  serdig_regfile #(.DIGITS(DIGITS), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_rf (
    .clk(clk), .rst(rst), .wr_en(commit), .wr_addr(frame_addr),
    .wr_data(frame_entry), .flat(digits_flat)
  );
endmodule

// File: rtl/serdig_if_chk.sv
module serdig_if_chk #(
  parameter int DIGITS = 10,
  parameter int ADDR_W = 4,
  parameter int FLAT_W = 60,
  parameter int CNT_W = 4,
  parameter int FRAME_MAX = 10,
  parameter int FRAME_MIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_rise,
  input logic              wr_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              accepted_n,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [FLAT_W-1:0] digits_flat
);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_MAX));

  assert_overrun_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && !wr_rise && bit_cnt == CNT_W'(FRAME_MAX)) |=> (bit_cnt == '0 && accepted_n));

  assert_ready_at_min_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(accepted_n) |-> bit_cnt == CNT_W'(FRAME_MIN));

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    wr_rise |=> (bit_cnt == '0 && accepted_n));

  assert_idle_write_no_store_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && accepted_n) |=> $stable(digits_flat));

  assert_bad_addr_no_store_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && int'(frame_addr) >= DIGITS) |=> $stable(digits_flat));
endmodule

bind serdig_if serdig_if_chk #(
  .DIGITS(DIGITS), .ADDR_W(ADDR_W), .FLAT_W(DIGITS*ENTRY_W), .CNT_W(CNT_W),
  .FRAME_MAX(FRAME_MAX), .FRAME_MIN(CODE_W + ADDR_W)
) u_chk (.*);

// File: tb/serdig_if_tb.sv
module serdig_if_tb;
  localparam int ND = 10;
  localparam int EW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_wr_n = 1'b1;
  logic accepted_n;
  logic [ND*EW-1:0] digits_flat;
  logic [ND*EW-1:0] model = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serdig_if u_dut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_wr_n(ser_wr_n), .accepted_n(accepted_n), .digits_flat(digits_flat)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_acc(input logic exp, input string req);
    checks++;
    if (accepted_n !== exp) begin
      errors++;
      $display("FAIL %s accepted_n actual=%b expected=%b", req, accepted_n, exp);
    end
  endtask

  task automatic chk_digits(input string req);
    checks++;
    if (digits_flat !== model) begin
      errors++;
      $display("FAIL %s digits actual=%h expected=%h", req, digits_flat, model);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    wait_cyc(3);
    ser_clk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic strobe;
    ser_wr_n = 1'b0;
    wait_cyc(3);
    ser_wr_n = 1'b1;
    wait_cyc(4);
  endtask

  // send order: an1, an2, c0..c3, a0..a3; the last len bits of that order
  task automatic send_frame(input int len, input logic an1, input logic an2,
                            input logic [3:0] code, input logic [3:0] addr);
    logic [9:0] ord;
    ord = {addr[3], addr[2], addr[1], addr[0], code[3], code[2], code[1], code[0], an2, an1};
    for (int i = 10 - len; i < 10; i++) send_bit(ord[i]);
  endtask

  function automatic logic [5:0] exp_entry(input int len, input logic an1,
                                           input logic an2, input logic [3:0] code);
    return {(len == 10) ? an1 : 1'b0, (len >= 9) ? an2 : 1'b0, code};
  endfunction

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    chk_acc(1'b1, "R8");
    chk_digits("R8");

    // sweep: every address, every legal length (R1 R3 R5 R7)
    for (int a = 0; a < 16; a++) begin
      for (int len = 8; len <= 10; len++) begin
        logic [3:0] code;
        logic an1, an2;
        code = 4'((a * 7 + len * 3) & 15);
        an1 = 1'((a + len) & 1);
        an2 = 1'(((a >> 1) + len + 1) & 1);
        send_frame(len, an1, an2, code, 4'(a));
        chk_acc(1'b0, "R2");
        strobe();
        if (a < ND) model[a*EW +: EW] = exp_entry(len, an1, an2, code);
        chk_acc(1'b1, "R5");
        chk_digits(a < ND ? "R1 R3" : "R7");
      end
    end

    // seven bits: not ready; eighth bit makes it ready (R2)
    send_frame(10, 1'b1, 1'b1, 4'h5, 4'h2);
    wait_cyc(1);
    strobe();
    model[2*EW +: EW] = 6'h35;
    chk_digits("R5");
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    chk_acc(1'b1, "R2");
    send_bit(1'b0);
    chk_acc(1'b0, "R2");
    send_bit(1'b1);
    chk_acc(1'b0, "R2");
    send_bit(1'b1);
    chk_acc(1'b0, "R2");
    // eleventh edge aborts (R4)
    send_bit(1'b1);
    chk_acc(1'b1, "R4");
    strobe();
    chk_digits("R4");

    // write while idle after a partial frame only resets (R6)
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    strobe();
    chk_acc(1'b1, "R6");
    chk_digits("R6");
    send_frame(9, 1'b0, 1'b1, 4'hA, 4'h9);
    strobe();
    model[9*EW +: EW] = 6'h1A;
    chk_digits("R6");

    // reset clears everything (R8)
    send_frame(8, 1'b0, 1'b0, 4'h3, 4'h0);
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    model = '0;
    wait_cyc(2);
    chk_acc(1'b1, "R8");
    chk_digits("R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule